// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block connects a 32-bit internal request port to an off-chip asynchronous device bus. The top four address bits pick one of four 256 MB chip-select windows. Every window has its own 32-bit timing word, written through a small register port. The timing word gives separate setup, strobe and hold lengths for reads and for writes. For each access the controller drives an active-low chip select, an output-enable strobe, a write strobe, a word address and write data. It counts each phase in controller clock cycles.

A requester raises `req_valid` while the controller is idle. The controller takes the request on that clock edge and raises `req_busy`. When the access is over, it pulses `rsp_done` for one cycle. For reads, the captured word is on `rsp_rdata` at that point. An address outside the four windows finishes at once and touches no external pin. Because each window keeps its own timing word, a slow converter and a faster static memory can share the bus, each with the timing it needs.

Top module: `async_xmem_ctrl`

## Requirements
- R1: An address whose bits 31:28 are 0x8, 0x9, 0xA or 0xB selects window 0, 1, 2 or 3 respectively. During that access only bit i of the active-low `ext_ce_n` is low, and at most one select bit is ever low.
- R2: An access whose address lies outside the four windows leaves `ext_ce_n`, `ext_oe_n` and `ext_we_n` high. `rsp_done` pulses in the cycle right after acceptance, and a read of this kind returns 0.
- R3: On the register port, byte offset 0x08 holds the timing word of window 0, 0x04 window 1, 0x10 window 2 and 0x14 window 3. Each reads back all 32 written bits. Every other offset reads 0, and a write to it changes no timing word.
- R4: The timing word is laid out as follows. Write setup is in [31:28], write strobe in [27:22] and write hold in {[3],[21:20]}. Read setup is in [19:16], read strobe in [13:8] and read hold in [2:0]. Bits [15:14] hold a turnaround value and bits [7:4] a memory type; both are stored but do not affect timing.
- R5: After reset, every timing word reads 0xFFFFFF2F: all lengths at their maximum and type 0010 (32-bit asynchronous).
- R6: For a read with setup S, strobe T and hold H, chip select is low for S+T+H cycles, starting in the cycle after acceptance. `ext_oe_n` is low for exactly the T cycles that follow the first S of them, and `ext_we_n` stays high.
- R7: For a write, the same phase structure applies with the write lengths. `ext_we_n` is low only in the strobe cycles, and `ext_oe_n` stays high. `ext_dout_en` is high and `ext_dout` equals the request data in every chip-select cycle.
- R8: A programmed setup or strobe length of 0 behaves as 1 cycle. A hold length of 0 adds no hold cycles.
- R9: A read returns on `rsp_rdata` the value `ext_din` had in the last strobe cycle. It holds that value until the next read completes.
- R10: `rsp_done` is high for exactly one cycle, the cycle after the last chip-select cycle. `req_busy` is high from the cycle after acceptance through the done cycle. A request raised while busy is ignored.
- R11: During a mapped access, `ext_addr` equals request address bits [EXT_AW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and external bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| req_busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Data from the last completed read |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at `cfg_addr` |
| ext_ce_n | output | 4 | Active-low window selects |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write enable |
| ext_addr | output | EXT_AW | External word address |
| ext_dout | output | 32 | External write data |
| ext_dout_en | output | 1 | Drive enable for `ext_dout` |
| ext_din | input | 32 | External read data |

## Verification
The bench builds the controller with its default EXT_AW of 26. This exposes every word-address bit of a 256 MB window, so a wrong address slice shows up on `ext_addr`. The phase counters are only six bits wide, so the bench can run the reset timing (15+63+7 cycles) directly. It also sweeps zero and non-zero setup, strobe and hold values through all four windows, with read and write lengths set differently in the same word. The external data model changes every cycle, so the captured read value shows exactly which strobe cycle was sampled.

// File: rtl/axm_pkg.sv
package axm_pkg;

    localparam int REG_W    = 32;
    localparam int DATA_W   = 32;
    localparam int NSPACE   = 4;
    localparam int SEL_W    = $clog2(NSPACE);
    localparam int OFF_W    = 5;
    localparam int SETUP_W  = 4;
    localparam int STROBE_W = 6;
    localparam int HOLD_W   = 3;
    localparam int CNT_W    = STROBE_W;

    localparam logic [3:0]       SPACE_BASE_NIB = 4'h8;
    localparam logic [3:0]       TYPE_ASYNC32   = 4'b0010;
    localparam logic [REG_W-1:0] CFG_RESET      = 32'hFFFF_FF2F;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
    } phase_t;

    typedef struct packed {
        phase_t     rd;
        phase_t     wr;
        logic [1:0] turn;
        logic [3:0] mtype;
    } space_cfg_t;

    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] idx;
    } slot_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } phase_e;

    // Split a raw timing word into its fields.
    function automatic space_cfg_t unpack_cfg(input logic [REG_W-1:0] r);
        space_cfg_t c;
        c.wr.setup  = r[31:28];
        c.wr.strobe = r[27:22];
        c.wr.hold   = {r[3], r[21:20]};
        c.rd.setup  = r[19:16];
        c.turn      = r[15:14];
        c.rd.strobe = r[13:8];
        c.mtype     = r[7:4];
        c.rd.hold   = r[2:0];
        return c;
    endfunction

    // Register-port offset to window index.
    function automatic slot_t offset_lookup(input logic [OFF_W-1:0] off);
        slot_t s;
        s.hit = 1'b1;
        s.idx = '0;
        case (off)
            5'h08:   s.idx = SEL_W'(0);
            5'h04:   s.idx = SEL_W'(1);
            5'h10:   s.idx = SEL_W'(2);
            5'h14:   s.idx = SEL_W'(3);
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

    // A length of zero is stretched to a single cycle.
    function automatic logic [CNT_W-1:0] len_or_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/axm_cfg_regs.sv
module axm_cfg_regs
    import axm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [OFF_W-1:0]              offset,
    input  logic [REG_W-1:0]              wdata,
    output logic [REG_W-1:0]              rdata,
    output logic [NSPACE-1:0][REG_W-1:0]  cfg_o
);

    slot_t                          slot;
    logic [NSPACE-1:0][REG_W-1:0]   cfg_q;

    always_comb slot = offset_lookup(offset);

    for (genvar i = 0; i < NSPACE; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= CFG_RESET;
            end else if (wr_en && slot.hit && (slot.idx == SEL_W'(i))) begin
                cfg_q[i] <= wdata;
            end
        end
    end

    always_comb rdata = slot.hit ? cfg_q[slot.idx] : '0;
    assign cfg_o = cfg_q;

    // Timing words move only on a register write.
    p_cfg_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/axm_addr_decode.sv
module axm_addr_decode
    import axm_pkg::*;
(
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [SEL_W-1:0] idx
);

    logic [3:0] nib;
    logic [3:0] rel;

    always_comb begin
        nib = addr[31:28];
        rel = nib - SPACE_BASE_NIB;
        hit = (nib >= SPACE_BASE_NIB) && (rel < 4'(NSPACE));
        idx = rel[SEL_W-1:0];
    end

endmodule

// File: rtl/axm_phase_seq.sv
module axm_phase_seq
    import axm_pkg::*;
#(
    parameter int EXT_AW = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_write,
    input  logic              space_hit,
    input  logic [SEL_W-1:0]  space_idx,
    input  phase_t            timing,
    input  logic [EXT_AW-1:0] word_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ext_din,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [NSPACE-1:0] ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [EXT_AW-1:0] addr_o,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    phase_e               st;
    logic [CNT_W-1:0]     cnt;
    logic                 wr_q;
    logic [SEL_W-1:0]     sel_q;
    logic [EXT_AW-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [DATA_W-1:0]    rdata_q;
    logic [STROBE_W-1:0]  strobe_q;
    logic [HOLD_W-1:0]    hold_q;
    logic                 last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            wr_q     <= 1'b0;
            sel_q    <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            strobe_q <= '0;
            hold_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        wr_q     <= is_write;
                        sel_q    <= space_idx;
                        addr_q   <= word_addr;
                        wdata_q  <= wdata;
                        strobe_q <= timing.strobe;
                        hold_q   <= timing.hold;
                        if (space_hit) begin
                            st  <= ST_SETUP;
                            cnt <= len_or_one(CNT_W'(timing.setup)) - CNT_W'(1);
                        end else begin
                            st <= ST_DONE;
                            if (!is_write) rdata_q <= '0;
                        end
                    end
                end
                ST_SETUP: begin
                    if (last) begin
                        st  <= ST_STROBE;
                        cnt <= len_or_one(CNT_W'(strobe_q)) - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_STROBE: begin
                    if (last) begin
                        if (!wr_q) rdata_q <= ext_din;
                        if (hold_q == '0) begin
                            st <= ST_DONE;
                        end else begin
                            st  <= ST_HOLD;
                            cnt <= CNT_W'(hold_q) - CNT_W'(1);
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (last) st <= ST_DONE;
                    else      cnt <= cnt - CNT_W'(1);
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    logic active;
    logic strobing;

    always_comb begin
        active   = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
        strobing = (st == ST_STROBE);
        ce_n     = active ? ~(NSPACE'(1) << sel_q) : '1;
        oe_n     = !(strobing && !wr_q);
        we_n     = !(strobing && wr_q);
        dout_en  = active && wr_q;
        dout     = wdata_q;
        addr_o   = addr_q;
        busy     = (st != ST_IDLE);
        done     = (st == ST_DONE);
        rdata    = rdata_q;
    end

    p_ce_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    p_oe_in_ce_r6: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (ce_n != '1));

    p_we_in_ce_r7: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (ce_n != '1));

    p_wdrive_r7: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dout_en);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(rdata) || $past(strobing));

endmodule

// File: rtl/async_xmem_ctrl.sv
module async_xmem_ctrl
    import axm_pkg::*;
#(
    parameter int EXT_AW = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_busy,
    output logic              rsp_done,
    output logic [31:0]       rsp_rdata,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic [3:0]        ext_ce_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [31:0]       ext_dout,
    output logic              ext_dout_en,
    input  logic [31:0]       ext_din
);

    logic [NSPACE-1:0][REG_W-1:0] cfg_raw;
    space_cfg_t                   cfg_s [NSPACE];
    space_cfg_t                   cfg_sel;
    phase_t                       timing;
    logic                         dec_hit;
    logic [SEL_W-1:0]             dec_idx;
    logic                         misc_unused;

    axm_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .offset (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .cfg_o  (cfg_raw)
    );

    for (genvar i = 0; i < NSPACE; i++) begin : g_unpack
        assign cfg_s[i] = unpack_cfg(cfg_raw[i]);
    end

    axm_addr_decode u_dec (
        .addr (req_addr),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    always_comb begin
        cfg_sel = cfg_s[dec_idx];
        timing  = req_write ? cfg_sel.wr : cfg_sel.rd;
    end

    // Stored fields that do not steer timing, and byte-lane address bits.
    assign misc_unused = ^{cfg_sel.turn, cfg_sel.mtype, req_addr[1:0]};

    axm_phase_seq #(.EXT_AW(EXT_AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (req_valid),
        .is_write  (req_write),
        .space_hit (dec_hit),
        .space_idx (dec_idx),
        .timing    (timing),
        .word_addr (req_addr[EXT_AW+1:2]),
        .wdata     (req_wdata),
        .ext_din   (ext_din),
        .busy      (req_busy),
        .done      (rsp_done),
        .rdata     (rsp_rdata),
        .ce_n      (ext_ce_n),
        .oe_n      (ext_oe_n),
        .we_n      (ext_we_n),
        .addr_o    (ext_addr),
        .dout      (ext_dout),
        .dout_en   (ext_dout_en)
    );

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_busy) |=> req_busy);

    p_unmapped_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_busy && !dec_hit) |=> (rsp_done && (ext_ce_n == '1)));

endmodule

// File: tb/tb_async_xmem_ctrl.sv
module tb_async_xmem_ctrl;

    localparam int CLK_P  = 10;
    localparam int EXT_AW = 26;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [31:0]       req_addr  = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_busy;
    logic              rsp_done;
    logic [31:0]       rsp_rdata;
    logic              cfg_we = 1'b0;
    logic [4:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic [3:0]        ext_ce_n;
    logic              ext_oe_n;
    logic              ext_we_n;
    logic [EXT_AW-1:0] ext_addr;
    logic [31:0]       ext_dout;
    logic              ext_dout_en;
    logic [31:0]       ext_din;
    logic [31:0]       cyc = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Device model: data changes every cycle.
    assign ext_din = {cyc[15:0], 6'd0, ext_addr[9:0]};

    async_xmem_ctrl #(.EXT_AW(EXT_AW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_busy(req_busy), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_ce_n(ext_ce_n),
        .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_dout_en(ext_dout_en), .ext_din(ext_din)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] off_of(input int sp);
        case (sp)
            0: return 5'h08;
            1: return 5'h04;
            2: return 5'h10;
            default: return 5'h14;
        endcase
    endfunction

    // Timing word per R4.
    function automatic logic [31:0] build_cfg(input int ws, input int wst, input int wh,
                                              input int rs, input int rst_, input int rh,
                                              input int ta);
        logic [31:0] r;
        r = '0;
        r[31:28] = 4'(ws);
        r[27:22] = 6'(wst);
        r[21:20] = 2'(wh);
        r[19:16] = 4'(rs);
        r[15:14] = 2'(ta);
        r[13:8]  = 6'(rst_);
        r[7:4]   = 4'b0010;
        r[3]     = 1'(wh >> 2);
        r[2:0]   = 3'(rh);
        return r;
    endfunction

    task automatic cfg_write(input logic [4:0] off, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = off; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [4:0] off, output logic [31:0] val);
        @(negedge clk);
        cfg_addr = off;
        #1 val = cfg_rdata;
    endtask

    task automatic run_txn(input bit wr, input logic [31:0] addr, input logic [31:0] wdata,
                           input int s, input int t, input int h,
                           input bit mapped, input int sp, input bit interfere, input string tag);
        int se, te, total, n, ce_cnt, str_cnt, first_str;
        bit ce_ok, addr_ok, drv_ok, busy_ok, wrong_str, got_done;
        logic [31:0] last_din;
        se = (s == 0) ? 1 : s;
        te = (t == 0) ? 1 : t;
        total = mapped ? (se + te + h) : 0;
        n = 0; ce_cnt = 0; str_cnt = 0; first_str = -1;
        ce_ok = 1; addr_ok = 1; drv_ok = 1; busy_ok = 1; wrong_str = 0; got_done = 0;
        last_din = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wdata;
        @(negedge clk);
        if (interfere) begin
            req_addr = 32'hB000_0040; req_write = ~wr; req_wdata = 32'h0BAD_0BAD;
        end else begin
            req_valid = 1'b0;
        end
        for (int guard = 0; guard < 400; guard++) begin
            if (!req_busy) busy_ok = 0;
            if (rsp_done) begin got_done = 1; break; end
            if (ext_ce_n != 4'hF) begin
                ce_cnt++;
                if (!mapped || ext_ce_n != ~(4'b0001 << sp)) ce_ok = 0;
                if (ext_addr != addr[EXT_AW+1:2]) addr_ok = 0;
                if (wr && !(ext_dout_en && ext_dout == wdata)) drv_ok = 0;
                if (!wr && ext_dout_en) drv_ok = 0;
            end
            if (wr ? !ext_oe_n : !ext_we_n) wrong_str = 1;
            if (wr ? !ext_we_n : !ext_oe_n) begin
                str_cnt++;
                if (first_str < 0) first_str = n;
                last_din = ext_din;
            end
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(got_done, {tag, " R10 done seen"}, 32'(got_done), 1);
        chk(n == total, {tag, " R10 done cycle"}, n, total);
        chk(busy_ok, {tag, " R10 busy"}, 32'(busy_ok), 1);
        chk(ce_ok, {tag, mapped ? " R1 select" : " R2 select"}, {28'd0, ext_ce_n}, 32'hF);
        chk(ce_cnt == total, {tag, wr ? " R7 ce len" : " R6 ce len"}, ce_cnt, total);
        chk(str_cnt == (mapped ? te : 0), {tag, " R8 strobe len"}, str_cnt, mapped ? te : 0);
        if (mapped)
            chk(first_str == se, {tag, " R8 strobe start"}, first_str, se);
        chk(!wrong_str, {tag, " R6 other strobe"}, 32'(wrong_str), 0);
        if (mapped) begin
            chk(addr_ok, {tag, " R11 address"}, {6'd0, ext_addr}, {6'd0, addr[EXT_AW+1:2]});
            chk(drv_ok, {tag, " R7 data drive"}, ext_dout, wdata);
        end
        if (!wr)
            chk(rsp_rdata == (mapped ? last_din : 32'h0), {tag, " R9 read data"},
                rsp_rdata, mapped ? last_din : 32'h0);
        @(negedge clk);
        chk(!rsp_done && !req_busy, {tag, " R10 after done"}, {30'd0, rsp_done, req_busy}, 0);
        if (interfere) begin
            bit idle_ok;
            idle_ok = 1;
            for (int k = 0; k < 3; k++) begin
                if (ext_ce_n != 4'hF || req_busy || rsp_done) idle_ok = 0;
                @(negedge clk);
            end
            chk(idle_ok, {tag, " R10 busy request ignored"}, 32'(idle_ok), 1);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int sv [3];
        int tv [4];
        int hv [4];
        int hw [4];
        int k;
        sv = '{0, 1, 2};
        tv = '{0, 1, 2, 5};
        hv = '{0, 1, 2, 7};
        hw = '{4, 0, 3, 1};
        k = 1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_busy && !rsp_done && ext_ce_n == 4'hF && ext_oe_n && ext_we_n
            && !ext_dout_en && rsp_rdata == 0, "R10 reset outputs",
            {ext_ce_n, 26'd0, req_busy, rsp_done}, 32'hF000_0000);

        // Reset values and register map.
        for (int sp = 0; sp < 4; sp++) begin
            cfg_read(off_of(sp), v);
            chk(v == 32'hFFFF_FF2F, "R5 reset word", v, 32'hFFFF_FF2F);
        end
        for (int j = 0; j < 4; j++) begin
            logic [4:0] o;
            o = (j == 0) ? 5'h00 : (j == 1) ? 5'h0C : (j == 2) ? 5'h18 : 5'h1C;
            cfg_write(o, 32'hDEAD_BEEF);
            cfg_read(o, v);
            chk(v == 0, "R3 unmapped offset reads zero", v, 0);
        end
        for (int sp = 0; sp < 4; sp++) begin
            cfg_read(off_of(sp), v);
            chk(v == 32'hFFFF_FF2F, "R3 unmapped write no effect", v, 32'hFFFF_FF2F);
        end

        // Maximum timing from reset.
        run_txn(0, 32'h9000_0100, 0, 15, 63, 7, 1, 1, 0, "R5 reset read");
        run_txn(1, 32'hB000_0200, 32'h1234_5678, 15, 63, 7, 1, 3, 0, "R5 reset write");

        // Unmapped addresses.
        run_txn(0, 32'h3000_0000, 0, 0, 0, 0, 0, 0, 0, "R2 low");
        run_txn(1, 32'hC000_0010, 32'h5555_AAAA, 0, 0, 0, 0, 0, 0, "R2 high");
        run_txn(0, 32'h7FFF_FFFC, 0, 0, 0, 0, 0, 0, 0, "R2 edge");

        // Sweep timing through all windows (R4 layout, R3 map).
        for (int sp = 0; sp < 4; sp++) begin
            for (int a = 0; a < 3; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int c = 0; c < 4; c++) begin
                        logic [31:0] word;
                        logic [31:0] ad;
                        word = build_cfg(sv[2-a], tv[3-b], hw[c], sv[a], tv[b], hv[c], c);
                        cfg_write(off_of(sp), word);
                        cfg_read(off_of(sp), v);
                        chk(v == word, "R3 readback", v, word);
                        ad = {4'(8 + sp), 28'(k * 32'h0012_3454)};
                        k++;
                        run_txn(0, ad, 0, sv[a], tv[b], hv[c], 1, sp, 0, "R4 sweep read");
                        run_txn(1, ad ^ 32'h0000_0F00, 32'hA500_0000 ^ 32'(k * 7919),
                                sv[2-a], tv[3-b], hw[c], 1, sp, 0, "R4 sweep write");
                    end
                end
            end
        end

        // Request held high while busy.
        cfg_write(off_of(1), build_cfg(1, 1, 1, 2, 3, 1, 0));
        run_txn(0, 32'h9000_0400, 0, 2, 3, 1, 1, 1, 1, "R10 interfere");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule